// File: doc/BRIEF.md
# Shortened BCH Parity Encoder with Bit-Reversed Bytes

This block computes the parity of a binary BCH code over one ECC chunk of 512 or 1024 bytes. The code lives in GF(2^m), where m is the smallest field order whose code length exceeds the chunk length in bits. The code is shortened to the chunk, which only means fewer message bits pass through the divider. The generator polynomial is the product of the distinct minimal polynomials of alpha^1 to alpha^(2T). It is computed at elaboration from the primitive polynomial and the strength T.

Bytes arrive one per clock, framed by a start marker and a last marker. The encoder absorbs eight message bits per clock through an unrolled LFSR division step. The block follows a hardware convention in which each input byte and each output parity byte is bit-reversed relative to a plain software encoder. One clock after the last byte, the parity is handed to an output shifter. The shifter emits it as bytes, most significant first. Meanwhile the divider is already free for the next chunk.

Top module: `bch_shortened_enc`

## Requirements
- R1: The field order M is the smallest value with 2^M greater than 8*CHUNK_BYTES (13 for 512 bytes, 14 for 1024). The parity is P = T*M bits, emitted as NB = ceil(P/8) bytes, with any padding as zeros below the lowest parity bit.
- R2: alpha is a root of the primitive polynomial PRIM_POLY, whose bit i is the coefficient of x^i. The default is 0x201B for M=13 and 0x4443 for M=14. Take the chunk bytes in order, each byte bit 0 first, and then the parity bits from highest to lowest. Read as coefficients from the highest degree down, this string is a polynomial that vanishes at alpha^1 through alpha^(2T).
- R3: Output byte k (k=0 is the first) carries the coefficient of x^(P-1-8k-j) in bit j, so each parity byte is bit-reversed against the most-significant-first remainder.
- R4: par_valid rises in the cycle after the clock edge that accepts a byte with in_last. It stays high for NB consecutive cycles, and par_last is high only in the final one.
- R5: A byte with in_start is absorbed into a cleared remainder, so a chunk of zero bytes yields all-zero parity whatever chunk preceded it.
- R6: Cycles with in_valid low change neither the remainder nor the result, so a chunk delivered with idle gaps gives the same parity as one without gaps.
- R7: A new chunk may start in the cycle right after the previous last byte. The previous parity frame then still completes unchanged, and the new chunk's parity is correct.
- R8: A one-byte chunk, with in_start and in_last in the same cycle, gives correct parity for every byte value.
- R9: During and right after reset, par_valid and par_last are low.
- R10: A last byte accepted while a frame is still being emitted abandons the rest of that frame without par_last. The new parity starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A message byte is present |
| in_start | input | 1 | First byte of a chunk |
| in_last | input | 1 | Final byte of a chunk |
| in_data | input | 8 | Message byte |
| par_valid | output | 1 | A parity byte is present |
| par_data | output | 8 | Parity byte, bit-reversed |
| par_last | output | 1 | Final parity byte of a frame |

## Verification
The two functions that can fall in the same cycle are absorbing a new chunk's first bytes and emitting the previous chunk's parity. The same overlap occurs with a short chunk whose last byte lands in the middle of an ongoing frame. The bench provokes the first overlap by starting a 512-byte chunk in the cycle after a previous last byte. It provokes the second with a three-byte chunk that ends three cycles into the previous frame. Each captured frame is judged by evaluating, in the bench's own GF(2^13) arithmetic, the 2T syndromes of message plus parity, all of which must be zero. Frame lengths must also match the abandon and continue rules.

// File: rtl/bch_enc_pkg.sv
`timescale 1ns/1ps
package bch_enc_pkg;

    // Multiply two field elements in GF(2^m) modulo prim, shift-and-add form.
    function automatic int gf_mul(input int a, input int b, input int m, input int prim);
        int r;
        r = 0;
        for (int k = m - 1; k >= 0; k--) begin
            r = r << 1;
            if (((r >> m) & 1) != 0) r = r ^ prim;
            if (((b >> k) & 1) != 0) r = r ^ a;
        end
        return r;
    endfunction

    // alpha^e using square-and-multiply, alpha represented by x (value 2).
    function automatic int gf_pow(input int e, input int m, input int prim);
        int r;
        int base;
        r    = 1;
        base = 2;
        for (int k = 0; k < m; k++) begin
            if (((e >> k) & 1) != 0) r = gf_mul(r, base, m, prim);
            base = gf_mul(base, base, m, prim);
        end
        return r;
    endfunction

    function automatic logic [7:0] bitrev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

endpackage

// File: rtl/bch_lfsr_byte.sv
`timescale 1ns/1ps
module bch_lfsr_byte #(
    parameter int         P   = 104,
    parameter logic [P:0] GEN = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_start,
    input  logic [7:0]   in_data,
    output logic [P-1:0] rem_nx
);
    import bch_enc_pkg::*;

    typedef struct packed {
        logic [P-1:0] rem;
    } lfsr_t;

    lfsr_t st_d, st_q;

    // Eight serial division steps unrolled into one clock.
    always_comb begin
        logic [P-1:0] r;
        logic [7:0]   rv;
        logic         fb;
        rv = bitrev8(in_data);
        r  = in_start ? '0 : st_q.rem;
        for (int s = 0; s < 8; s++) begin
            fb = r[P-1] ^ rv[7-s];
            r  = {r[P-2:0], 1'b0} ^ (fb ? GEN[P-1:0] : '0);
        end
        rem_nx = r;
        st_d   = st_q;
        if (in_valid) st_d.rem = r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start && in_data == 8'h00) |=> (st_q.rem == '0)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.rem)); // R6

endmodule

// File: rtl/bch_par_ser.sv
`timescale 1ns/1ps
module bch_par_ser #(
    parameter int P  = 104,
    parameter int NB = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [P-1:0] rem_in,
    output logic         par_valid,
    output logic [7:0]   par_data,
    output logic         par_last
);
    import bch_enc_pkg::*;

    localparam int W   = NB * 8;
    localparam int PAD = W - P;
    localparam int CW  = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] idx;
        logic          act;
    } ser_t;

    ser_t st_d, st_q;
    logic [W-1:0] padded;

    generate
        if (PAD == 0) begin : g_nopad
            assign padded = rem_in;
        end else begin : g_pad
            assign padded = {rem_in, {PAD{1'b0}}};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh  = padded;
            st_d.idx = '0;
            st_d.act = 1'b1;
        end else if (st_q.act) begin
            if (st_q.idx == CW'(NB - 1)) begin
                st_d.act = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.sh  = st_q.sh << 8;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_valid = st_q.act;
    assign par_data  = bitrev8(st_q.sh[W-1 -: 8]);
    assign par_last  = st_q.act && (st_q.idx == CW'(NB - 1));

    AST_LAST_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        par_last |-> par_valid); // R4
    AST_FRAME_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !par_last) |=> par_valid); // R4
    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (par_last && !load) |=> !par_valid); // R4

endmodule

// File: rtl/bch_shortened_enc.sv
`timescale 1ns/1ps
module bch_shortened_enc #(
    parameter int CHUNK_BYTES = 512,
    parameter int T           = 8,
    parameter int PRIM_POLY   = ($clog2(CHUNK_BYTES * 8 + 1) == 13) ? 'h201B :
                                ($clog2(CHUNK_BYTES * 8 + 1) == 14) ? 'h4443 : 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       in_last,
    input  logic [7:0] in_data,
    output logic       par_valid,
    output logic [7:0] par_data,
    output logic       par_last
);
    import bch_enc_pkg::*;

    localparam int M  = $clog2(CHUNK_BYTES * 8 + 1);
    localparam int P  = T * M;
    localparam int NB = (P + 7) / 8;
    localparam int NF = (1 << M) - 1;

    // Product of the minimal polynomials of alpha^1 .. alpha^(2T), one per coset.
    function automatic logic [P:0] gen_poly();
        logic [P:0]         g;
        logic [P:0]         acc;
        logic [16:0][15:0]  mp;
        int                 c;
        int                 root;
        bit                 lead;
        g    = '0;
        g[0] = 1'b1;
        for (int i = 1; i < 2 * T; i += 2) begin
            lead = 1'b1;
            c    = i;
            for (int j = 1; j < M; j++) begin
                c = (c * 2) % NF;
                if (c < i) lead = 1'b0;
            end
            if (lead) begin
                mp    = '0;
                mp[0] = 16'd1;
                c     = i;
                for (int j = 0; j < M; j++) begin
                    if (j == 0 || c != i) begin
                        root = gf_pow(c, M, PRIM_POLY);
                        for (int k = 16; k >= 1; k--)
                            mp[k] = mp[k-1] ^ 16'(gf_mul(int'(mp[k]), root, M, PRIM_POLY));
                        mp[0] = 16'(gf_mul(int'(mp[0]), root, M, PRIM_POLY));
                        c = (c * 2) % NF;
                    end
                end
                acc = '0;
                for (int k = 0; k <= 16; k++)
                    if (mp[k][0]) acc = acc ^ (g << k);
                g = acc;
            end
        end
        return g;
    endfunction

    localparam logic [P:0] GEN = gen_poly();

    logic [P-1:0] rem_nx;
    logic         load;

    assign load = in_valid && in_last;

    bch_lfsr_byte #(.P(P), .GEN(GEN)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_data  (in_data),
        .rem_nx   (rem_nx)
    );

    bch_par_ser #(.P(P), .NB(NB)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .rem_in    (rem_nx),
        .par_valid (par_valid),
        .par_data  (par_data),
        .par_last  (par_last)
    );

    AST_PAR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> par_valid); // R4
    AST_RESTART_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> !par_last); // R10

endmodule

// File: tb/bch_shortened_enc_test.sv
`timescale 1ns/1ps
module bch_shortened_enc_test;

    localparam int CB  = 512;
    localparam int TT  = 8;
    localparam int BM  = $clog2(CB * 8 + 1);
    localparam int BP  = TT * BM;
    localparam int BNB = (BP + 7) / 8;
    localparam int PR  = 'h201B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       par_valid;
    logic [7:0] par_data;
    logic       par_last;

    bch_shortened_enc #(.CHUNK_BYTES(CB), .T(TT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .par_valid(par_valid),
        .par_data(par_data), .par_last(par_last)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [7:0] msg_a [0:CB-1];
    logic [7:0] msg_b [0:CB-1];
    logic [7:0] fr_b  [0:3][0:BNB-1];
    int         fr_len[0:3];
    int         fr_n = 0;
    logic [7:0] win   [0:BNB-1];
    int         wcnt = 0;
    logic [7:0] keep  [0:BNB-1];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            finish_run();
        end
    end

    // Frame collector, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && par_valid) begin
            for (int k = 0; k < BNB - 1; k++) win[k] = win[k+1];
            win[BNB-1] = par_data;
            wcnt++;
            if (par_last) begin
                for (int k = 0; k < BNB; k++) fr_b[fr_n % 4][k] = win[k];
                fr_len[fr_n % 4] = wcnt;
                wcnt = 0;
                fr_n++;
            end
        end
    end

    // Full product then reduction: a second, independent field multiply.
    function automatic int gmul(input int a, input int b);
        longint prod;
        prod = 0;
        for (int i = 0; i < BM; i++)
            if (((b >> i) & 1) != 0) prod = prod ^ (longint'(a) << i);
        for (int d = 2 * BM - 2; d >= BM; d--)
            if (((prod >> d) & 1) != 0) prod = prod ^ (longint'(PR) << (d - BM));
        return int'(prod);
    endfunction

    function automatic int nz_syn(input int f, input bit selb, input int len);
        int cnt;
        int a;
        int s;
        int bitv;
        cnt = 0;
        for (int i = 1; i <= 2 * TT; i++) begin
            a = 1;
            for (int e = 0; e < i; e++) a = gmul(a, 2);
            s = 0;
            for (int b = 0; b < len; b++)
                for (int j = 0; j < 8; j++) begin
                    bitv = selb ? int'(msg_b[b][j]) : int'(msg_a[b][j]);
                    s = gmul(s, a) ^ bitv;
                end
            for (int k = 0; k < BNB; k++)
                for (int j = 0; j < 8; j++)
                    if (k * 8 + j < BP) s = gmul(s, a) ^ int'(fr_b[f % 4][k][j]);
            if (s != 0) cnt++;
        end
        return cnt;
    endfunction

    task automatic send(input bit selb, input int len, input int gap, input bit idle_after);
        for (int b = 0; b < len; b++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_start = (b == 0);
            in_last  = (b == len - 1);
            in_data  = selb ? msg_b[b] : msg_a[b];
            if (gap > 0 && (b % gap) == gap - 1 && b != len - 1) begin
                @(posedge clk); #1;
                in_valid = 1'b0;
                in_start = 1'b0;
                in_last  = 1'b0;
                in_data  = 8'hA5;
            end
        end
        if (idle_after) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_start = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic wait_frames(input int n);
        while (fr_n < n) @(negedge clk);
    endtask

    task automatic verify(input int f, input bit selb, input int len,
                          input int exp_len, input string req);
        int z;
        check(fr_len[f % 4] == exp_len, req, "frame length", fr_len[f % 4], exp_len);
        z = nz_syn(f, selb, len);
        check(z == 0, req, "nonzero syndromes", z, 0);
    endtask

    initial begin
        int z;
        int f0;
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(par_valid == 1'b0, "R9", "par_valid in reset", int'(par_valid), 0);
        check(par_last == 1'b0, "R9", "par_last in reset", int'(par_last), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(par_valid == 1'b0, "R9", "par_valid after reset", int'(par_valid), 0);

        // R5 / R1: all-zero chunk gives zero parity, NB bytes
        for (int b = 0; b < CB; b++) msg_a[b] = 8'h00;
        send(1'b0, CB, 0, 1'b1);
        wait_frames(1);
        z = 0;
        for (int k = 0; k < BNB; k++) if (fr_b[0][k] != 8'h00) z++;
        check(z == 0, "R5", "nonzero parity bytes for zero chunk", z, 0);
        verify(0, 1'b0, CB, BNB, "R1");

        // R2 / R3: pseudo-random chunk
        for (int b = 0; b < CB; b++) msg_a[b] = 8'($urandom);
        send(1'b0, CB, 0, 1'b1);
        wait_frames(2);
        verify(1, 1'b0, CB, BNB, "R2");
        for (int k = 0; k < BNB; k++) keep[k] = fr_b[1][k];

        // R6: same chunk with idle gaps must give identical bytes
        send(1'b0, CB, 7, 1'b1);
        wait_frames(3);
        z = 0;
        for (int k = 0; k < BNB; k++) if (fr_b[2][k] != keep[k]) z++;
        check(z == 0, "R6", "bytes differing with gaps", z, 0);
        verify(2, 1'b0, CB, BNB, "R6");

        // R3: all-ones chunk
        for (int b = 0; b < CB; b++) msg_a[b] = 8'hFF;
        send(1'b0, CB, 0, 1'b1);
        wait_frames(4);
        verify(3, 1'b0, CB, BNB, "R3");

        // R5: zero chunk right after a nonzero one
        for (int b = 0; b < CB; b++) msg_a[b] = 8'h00;
        send(1'b0, CB, 0, 1'b1);
        wait_frames(5);
        z = 0;
        for (int k = 0; k < BNB; k++) if (fr_b[4 % 4][k] != 8'h00) z++;
        check(z == 0, "R5", "stale parity after prior chunk", z, 0);

        // R7: back-to-back chunks, parity of A emitted while B is absorbed
        for (int b = 0; b < CB; b++) begin
            msg_a[b] = 8'(b * 7 + 3);
            msg_b[b] = 8'($urandom);
        end
        f0 = fr_n;
        send(1'b0, CB, 0, 1'b0);
        send(1'b1, CB, 0, 1'b1);
        wait_frames(f0 + 2);
        verify(f0, 1'b0, CB, BNB, "R7");
        verify(f0 + 1, 1'b1, CB, BNB, "R7");

        // R10: three-byte chunk ends during A's frame
        for (int b = 0; b < CB; b++) msg_a[b] = 8'($urandom);
        msg_b[0] = 8'h3C; msg_b[1] = 8'h81; msg_b[2] = 8'hE7;
        f0 = fr_n;
        send(1'b0, CB, 0, 1'b0);
        send(1'b1, 3, 0, 1'b1);
        wait_frames(f0 + 1);
        verify(f0, 1'b1, 3, 3 + BNB, "R10");
        repeat (BNB + 4) @(posedge clk);
        check(fr_n == f0 + 1, "R10", "frames after restart", fr_n, f0 + 1);

        // R8 / R4: every one-byte chunk
        for (int v = 0; v < 256; v++) begin
            msg_a[0] = 8'(v);
            f0 = fr_n;
            @(posedge clk); #1;
            in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1; in_data = 8'(v);
            @(posedge clk); #1;
            in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
            @(negedge clk);
            check(par_valid == 1'b1, "R4", "par_valid one cycle after last", int'(par_valid), 1);
            wait_frames(f0 + 1);
            verify(f0, 1'b0, 1, BNB, "R8");
        end

        finish_run();
    end

endmodule